// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. Software programs an expiry action and a 4-bit interval code. It then sets the enable bit and must keep writing a keyed service word to the kick register. If no valid kick arrives before the selected interval runs out, the block raises a one-clock system reset request. It also latches an expired flag that software can read.

Time is counted in half-second units. A prescaler divides the core clock by `HALF_SEC_CYCLES`. The interval code maps onto a nonlinear table that runs from half a second up to sixteen seconds. A write to the kick register is honoured only when it carries the service key together with its strobe bit, so a stray store cannot keep the watchdog quiet. Changing the interval code has no effect on a countdown already running. The new code takes effect at the next kick, or when the timer is enabled from the stopped state.

Top module: `keyed_watchdog`

## Requirements
- R1: After synchronous reset the config and mode registers read 0, no reset request is driven, and the timer is stopped.
- R2: Offset 0x14 reads back the action field in bits [1:0]. Offset 0x18 reads back the enable in bit 0, the expired flag in bit 1 and the interval code in bits [7:4]. All other bits read 0. Offset 0x10 always reads 0.
- R3: A write to 0x10 whose bit 0 is 1 and whose bits [12:1] equal 0xA57 (low 13 bits 0x14AF) is a valid kick. It restarts the prescaler, reloads the countdown from the current code and clears the expired flag.
- R4: Any other write to 0x10 has no effect: it changes neither the expiry time nor the expired flag.
- R5: Measured from the clock edge that takes a kick, the reset request rises exactly L*HALF_SEC_CYCLES cycles later. L is the load in half seconds: code 0 gives 1, codes 1..6 give 2*code, codes 7, 8, 9, 10 give 16, 20, 24, 28, and codes 11..15 give 32.
- R6: On expiry with action 01 the reset request is high for exactly one cycle. Mode bit 1 then reads 1 and stays 1, and no further request follows until a kick or a disable.
- R7: On expiry with an action other than 01, mode bit 1 is set but no reset request is driven.
- R8: A mode write with bit 0 equal to 0 stops the timer and clears the expired flag in the same edge. No reset request follows while the timer is stopped.
- R9: A mode write that sets the enable while the timer is already enabled neither clears a pending expired flag nor restarts the countdown.
- R10: A new interval code written while enabled does not change the running countdown. It is used from the next valid kick.
- R11: A mode write that sets the enable while the timer is stopped loads the countdown from the code written in that same write. The reset request then follows L*HALF_SEC_CYCLES cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `HALF_SEC_CYCLES` set to 3 and keeps the default 8-bit address and 32-bit data widths. With that prescaler the longest interval is 96 cycles. Every interval code, including the codes above 11 that saturate, can therefore be timed to the exact edge in a short run. The prescaler also wraps often enough that kicks, corrupted kicks and mode writes land at many different prescaler phases. Random codes, actions and bad-key placements are mixed with directed sequences for re-enable, code change while running and stop.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W = 6;
  localparam int KEY_W = 12;
  localparam logic [KEY_W-1:0] KICK_KEY = 12'hA57;
  localparam logic [7:0] OFF_CTRL = 8'h10;
  localparam logic [7:0] OFF_CFG  = 8'h14;
  localparam logic [7:0] OFF_MODE = 8'h18;
  localparam logic [1:0] ACT_SYSRESET = 2'b01;

  typedef struct packed {
    logic             reload;       // restart prescaler and load countdown
    logic             halt;         // stop write seen this cycle
    logic             run;          // enable level
    logic             resetAction;  // expiry drives the reset request
    logic [CNT_W-1:0] loadHalfSecs; // load value in half-second units
  } wdgStrobe_t;

  // interval code -> half-second units
  function automatic logic [CNT_W-1:0] halfSecs(input logic [3:0] code);
    logic [CNT_W-1:0] v;
    case (code)
      4'd0:    v = CNT_W'(1);
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6:
               v = CNT_W'({code, 1'b0});
      4'd7:    v = CNT_W'(16);
      4'd8:    v = CNT_W'(20);
      4'd9:    v = CNT_W'(24);
      4'd10:   v = CNT_W'(28);
      default: v = CNT_W'(32);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              expired,
  output logic [DATA_W-1:0] busRdata,
  output wdgStrobe_t        strobe
);
  logic       enable;
  logic [3:0] code;
  logic [1:0] action;

  logic selCtrl, selCfg, selMode;
  logic ctrlWr, cfgWr, modeWr;
  logic keyOk, kick, enRise, haltWr;
  logic unusedHiBits;

  assign selCtrl = (busAddr == ADDR_W'(OFF_CTRL));
  assign selCfg  = (busAddr == ADDR_W'(OFF_CFG));
  assign selMode = (busAddr == ADDR_W'(OFF_MODE));

  assign ctrlWr = busWe && selCtrl;
  assign cfgWr  = busWe && selCfg;
  assign modeWr = busWe && selMode;

  assign keyOk  = busWdata[0] && (busWdata[KEY_W:1] == KICK_KEY);
  assign kick   = ctrlWr && keyOk;
  assign enRise = modeWr && busWdata[0] && !enable;
  assign haltWr = modeWr && !busWdata[0];

  assign unusedHiBits = ^busWdata[DATA_W-1:KEY_W+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      code   <= 4'd0;
      action <= 2'b00;
    end else begin
      if (cfgWr) action <= busWdata[1:0];
      if (modeWr) begin
        enable <= busWdata[0];
        code   <= busWdata[7:4];
      end
    end
  end

  always_comb begin
    strobe.reload       = kick || enRise;
    strobe.halt         = haltWr;
    strobe.run          = enable;
    strobe.resetAction  = (action == ACT_SYSRESET);
    strobe.loadHalfSecs = enRise ? halfSecs(busWdata[7:4]) : halfSecs(code);
  end

  always_comb begin
    busRdata = '0;
    if (selCfg) begin
      busRdata[1:0] = action;
    end else if (selMode) begin
      busRdata[0]   = enable;
      busRdata[1]   = expired;
      busRdata[7:4] = code;
    end
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int HALF_SEC_CYCLES = 12_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  wdgStrobe_t strobe,
  output logic       expired,
  output logic       sysResetReq
);
  localparam int PRE_W = (HALF_SEC_CYCLES > 1) ? $clog2(HALF_SEC_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(HALF_SEC_CYCLES - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] halfLeft;
  logic             tick;

  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt      <= '0;
      halfLeft    <= '0;
      expired     <= 1'b0;
      sysResetReq <= 1'b0;
    end else begin
      sysResetReq <= 1'b0;
      if (strobe.reload) begin
        preCnt   <= '0;
        halfLeft <= strobe.loadHalfSecs;
        expired  <= 1'b0;
      end else if (strobe.halt || !strobe.run) begin
        preCnt  <= '0;
        expired <= 1'b0;
      end else if (!expired) begin
        if (tick) begin
          preCnt <= '0;
          if (halfLeft <= CNT_W'(1)) begin
            halfLeft    <= '0;
            expired     <= 1'b1;
            sysResetReq <= strobe.resetAction;
          end else begin
            halfLeft <= halfLeft - CNT_W'(1);
          end
        end else begin
          preCnt <= preCnt + PRE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int DATA_W          = 32,
  parameter int HALF_SEC_CYCLES = 12_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sysResetReq
);
  wdgStrobe_t strobe;
  logic       expired;

  wdg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .expired  (expired),
    .busRdata (busRdata),
    .strobe   (strobe)
  );

  wdg_timer #(.HALF_SEC_CYCLES(HALF_SEC_CYCLES)) uTimer (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .expired     (expired),
    .sysResetReq (sysResetReq)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic              sysResetReq
);
  logic [1:0] actShadow;
  logic       enShadow;
  logic       kickWr, haltWr;
  logic       unusedHi;

  assign unusedHi = ^busWdata[DATA_W-1:KEY_W+1];
  assign kickWr = busWe && (busAddr == ADDR_W'(OFF_CTRL)) && busWdata[0]
                  && (busWdata[KEY_W:1] == KICK_KEY);
  assign haltWr = busWe && (busAddr == ADDR_W'(OFF_MODE)) && !busWdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      actShadow <= 2'b00;
      enShadow  <= 1'b0;
    end else if (busWe) begin
      if (busAddr == ADDR_W'(OFF_CFG))  actShadow <= busWdata[1:0];
      if (busAddr == ADDR_W'(OFF_MODE)) enShadow  <= busWdata[0];
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sysResetReq |=> !sysResetReq); // R6
  AST_KICK_QUIETS: assert property (@(posedge clk) disable iff (rst)
    kickWr |=> !sysResetReq); // R3
  AST_HALT_QUIETS: assert property (@(posedge clk) disable iff (rst)
    haltWr |=> !sysResetReq); // R8
  AST_ACTION_GATES: assert property (@(posedge clk) disable iff (rst)
    sysResetReq |-> ($past(actShadow) == ACT_SYSRESET)); // R7
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
    sysResetReq |-> $past(enShadow)); // R8
endmodule

bind keyed_watchdog wdg_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rst         (rst),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .busWdata    (busWdata),
  .sysResetReq (sysResetReq)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  localparam int H = 3;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_CFG  = 8'h14;
  localparam logic [7:0] A_MODE = 8'h18;
  localparam logic [31:0] KICK  = 32'h0000_14AF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  busAddr = 8'h00;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sysResetReq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  keyed_watchdog #(.ADDR_W(8), .DATA_W(32), .HALF_SEC_CYCLES(H)) u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .sysResetReq(sysResetReq));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int expL(input logic [3:0] c);
    if (c == 0) return 1;
    if (c <= 6) return 2 * c;
    if (c <= 10) return 16 + 4 * (c - 7);
    return 32;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  // waits n cycles, optional bad control write at step badAt
  task automatic watch(input int n, input int badAt, input logic [31:0] badVal,
                       output int first, output int highs);
    first = -1; highs = 0;
    for (int k = 1; k <= n; k++) begin
      if (k == badAt) begin busAddr = A_CTRL; busWdata = badVal; busWe = 1'b1; end
      @(negedge clk);
      busWe = 1'b0;
      if (sysResetReq) begin
        highs++;
        if (first < 0) first = cyc;
      end
    end
  endtask

  initial begin
    #(100000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int first, highs, t0, seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CFG, r);  chk(r == 0, "R1 cfg", r, 0);
    rd(A_MODE, r); chk(r == 0, "R1 mode", r, 0);
    chk(sysResetReq == 0, "R1 req", sysResetReq, 0);
    watch(40, 0, 0, first, highs);
    chk(highs == 0, "R1 stopped", highs, 0);

    // R2 readback
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, r); chk(r == 32'h3, "R2 cfg", r, 3);
    wr(A_MODE, 32'hFFFF_FFF1); rd(A_MODE, r); chk(r == 32'hF1, "R2 mode", r, 32'hF1);
    wr(A_CTRL, KICK); rd(A_CTRL, r); chk(r == 0, "R2 ctrl", r, 0);
    wr(A_MODE, 0);

    // R5/R6/R7/R4 random mix with directed codes first
    for (int it = 0; it < 26; it++) begin
      logic [3:0] code;
      logic [1:0] act;
      logic [31:0] bad;
      int badAt, L;
      code = (it == 0) ? 4'd0 : (it == 1) ? 4'd12 : (it == 2) ? 4'd15 : 4'($urandom % 16);
      act  = (it < 3) ? 2'b01 : 2'($urandom % 4);
      L = expL(code);
      badAt = 0;
      bad = 32'h0000_14AE;
      if ($urandom % 2 == 1 && L * H > 4) begin
        badAt = 1 + ($urandom % (L * H - 3));
        if ($urandom % 2 == 1) begin
          logic [11:0] k;
          k = 12'($urandom);
          if (k == 12'hA57) k = k ^ 12'h001;
          bad = {19'($urandom), k, 1'b1};
        end
      end
      wr(A_MODE, 0);
      wr(A_CFG, {30'd0, act});
      wr(A_MODE, {24'd0, code, 4'h1});
      wr(A_CTRL, KICK);
      t0 = cyc;
      watch(L * H + 6, badAt, bad, first, highs);
      if (act == 2'b01) begin
        chk(first == t0 + L * H, "R5 expiry time", first - t0, L * H);
        chk(highs == 1, "R6 one pulse", highs, 1);
        if (badAt != 0) chk(first == t0 + L * H, "R4 bad kick ignored", first - t0, L * H);
      end else begin
        chk(highs == 0, "R7 no pulse", highs, 0);
      end
      rd(A_MODE, r);
      chk(r[1] == 1'b1, "R6 R7 expired flag", r[1], 1);
    end

    // R6 sticky, R9 re-enable, R4 ignored write keeps flag
    wr(A_MODE, 0); wr(A_CFG, 1); wr(A_MODE, 32'h21); wr(A_CTRL, KICK);
    watch(4 * H + 2, 0, 0, first, highs);
    chk(highs == 1, "R6 pulse", highs, 1);
    wr(A_MODE, 32'h21);
    rd(A_MODE, r); chk(r[1] == 1'b1, "R9 flag kept", r[1], 1);
    wr(A_CTRL, 32'h0000_14AE);
    rd(A_MODE, r); chk(r[1] == 1'b1, "R4 strobe-less kick", r[1], 1);
    watch(60, 0, 0, first, highs);
    chk(highs == 0, "R6 no repeat", highs, 0);

    // R8 disable clears flag immediately, then silence
    wr(A_MODE, 0);
    rd(A_MODE, r); chk(r == 0, "R8 cleared", r, 0);
    wr(A_MODE, 32'h11); wr(A_CTRL, KICK);
    watch(H, 0, 0, first, highs);
    wr(A_MODE, 0);
    watch(40, 0, 0, first, highs);
    chk(highs == 0, "R8 stop", highs, 0);

    // R9 re-enable while running does not restart
    wr(A_MODE, 32'h21); wr(A_CTRL, KICK); t0 = cyc;
    watch(5, 0, 0, first, highs);
    wr(A_MODE, 32'h21);
    watch(4 * H, 0, 0, first, highs);
    chk(first == t0 + 4 * H, "R9 no restart", first - t0, 4 * H);

    // R3 second kick reloads
    wr(A_MODE, 0); wr(A_MODE, 32'h21); wr(A_CTRL, KICK);
    watch(7, 0, 0, first, highs);
    wr(A_CTRL, KICK); t0 = cyc;
    watch(4 * H + 4, 0, 0, first, highs);
    chk(first == t0 + 4 * H, "R3 reload", first - t0, 4 * H);
    rd(A_MODE, r); chk(r[1] == 1'b1, "R3 expired set", r[1], 1);
    wr(A_CTRL, KICK | 32'hFFFF_E000);
    rd(A_MODE, r); chk(r[1] == 1'b0, "R3 kick clears flag", r[1], 0);

    // R10 code change while running waits for next kick
    wr(A_MODE, 0); wr(A_MODE, 32'h11); wr(A_CTRL, KICK); t0 = cyc;
    wr(A_MODE, 32'hB1);
    watch(2 * H + 2, 0, 0, first, highs);
    chk(first == t0 + 2 * H, "R10 old code", first - t0, 2 * H);
    wr(A_CTRL, KICK); t0 = cyc;
    watch(32 * H + 3, 0, 0, first, highs);
    chk(first == t0 + 32 * H, "R10 new code", first - t0, 32 * H);

    // R11 enable from stopped loads written code
    wr(A_MODE, 0); wr(A_MODE, 32'h31); t0 = cyc;
    watch(6 * H + 3, 0, 0, first, highs);
    chk(first == t0 + 6 * H, "R11 enable load", first - t0, 6 * H);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule